// File: doc/BRIEF.md
# Segment Frame Parser for a Flagged Byte Stream

The parser watches a receive byte stream that delivers one byte per clock together with a flag that marks control (K) characters. Inside that stream, framed data segments are carried at half rate. A frame opens with a start marker. After the marker come one skipped byte, a segment-number byte and a second skipped byte. Payload bytes then arrive on every other cycle, and the cycles between them carry unrelated traffic. A close marker at a payload slot ends the frame.

For each payload byte the parser puts out a one-cycle write strobe, the byte, and an 11-bit buffer address. The address is the segment number scaled by eight plus the running byte index, so the output can drive the write port of a segment memory directly. When a frame closes normally, the parser registers the segment number and the byte count and raises a one-cycle completion pulse.

The controller has six states:
- `ST_IDLE`: waits for the start marker.
- `ST_LEAD_SKIP`: drops the byte after the marker.
- `ST_ADDR`: latches the segment number.
- `ST_PAD_SKIP`: drops one more byte.
- `ST_TAKE`: a payload slot.
- `ST_GAP`: an ignored slot between payload bytes.

Its transitions are:
- A start marker moves any state to `ST_LEAD_SKIP`.
- `ST_LEAD_SKIP` always goes to `ST_ADDR`, `ST_ADDR` to `ST_PAD_SKIP`, and `ST_PAD_SKIP` to `ST_TAKE`.
- `ST_TAKE` goes to `ST_GAP` after capturing a data byte. It returns to `ST_IDLE` on a close marker (completion), on any other K character (abort) or on a data byte that would exceed capacity (abort).
- `ST_GAP` always goes back to `ST_TAKE`.

Top module: `seg_frame_parser`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `wr_valid` and `seg_done` are 0 and `wr_data`, `wr_addr`, `seg_len` and `seg_num` are 0.
- R2: The start marker is byte 0x5C with `rx_is_k`=1. Counting the marker as position 0, position 1 is skipped, position 2 is latched as the segment number, position 3 is skipped and position 4 is the first payload slot. This holds even when the marker arrives during a skip or address position of an earlier frame.
- R3: Payload slots are the even positions from 4 upward, and the odd positions between them are ignored, including any K character other than the start marker. Each data byte (`rx_is_k`=0) in a payload slot makes `wr_valid` high for exactly one cycle, with `wr_data` equal to that byte, in the cycle after the byte is presented.
- R4: The payload byte with index i (counting from 0) in segment s is written at `wr_addr` = (s*8 + i) mod 2048.
- R5: The close marker is byte 0x3C with `rx_is_k`=1 in a payload slot. One cycle after it, `seg_done` is high for one cycle, `seg_len` equals the number of bytes captured (0 for an empty frame) and `seg_num` equals the segment number. The parser then ignores bytes until the next start marker.
- R6: A close marker at an ignored (odd) position has no effect, and the frame continues.
- R7: Any K character other than the two markers in a payload slot aborts the frame. No `seg_done` pulse follows, and no write occurs until the next start marker.
- R8: A segment holds up to 2048 bytes. A close marker after 2048 bytes reports `seg_len`=2048. A data byte in a payload slot after 2048 bytes aborts the frame without a write or `seg_done`.
- R9: Outside a frame, every byte is ignored except the start marker, including close markers and data.
- R10: A start marker inside a payload phase abandons the open frame without a `seg_done` pulse, and a new frame starts at that marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_is_k | input | 1 | Byte is a K character |
| wr_valid | output | 1 | One-cycle strobe for a captured payload byte |
| wr_data | output | 8 | Captured payload byte |
| wr_addr | output | 11 | Buffer address of the captured byte |
| seg_done | output | 1 | One-cycle pulse on a normal frame close |
| seg_len | output | 12 | Byte count of the closed segment |
| seg_num | output | 8 | Segment number of the closed segment |

## Verification
Randomly generated frames are used, with random segment numbers, lengths and gap traffic. Some gap slots carry close markers or other K characters, which separates a parser that takes alternate slots from one that takes every byte or treats a K character in a gap as meaningful. Directed frames cover the following cases:
- an empty frame;
- an address that wraps past 2047;
- an abort on a foreign K character, followed by data that must be dropped;
- a restart in the middle of the payload and a restart during the skip positions;
- exactly 2048 bytes against 2049 bytes, which shows whether capacity is enforced at the right count.

Junk traffic between frames, including stray close markers, shows whether the parser really waits for the start marker.

// File: rtl/seg_parse_pkg.sv
package seg_parse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_SKIP,
        ST_ADDR,
        ST_PAD_SKIP,
        ST_TAKE,
        ST_GAP
    } parse_state_t;

    typedef struct packed {
        logic open_mark;
        logic close_mark;
        logic other_k;
    } sym_class_t;

endpackage

// File: rtl/seg_sym_classify.sv
module seg_sym_classify
    import seg_parse_pkg::*;
#(
    parameter int          BYTE_W     = 8,
    parameter logic [7:0]  OPEN_CODE  = 8'h5C,
    parameter logic [7:0]  CLOSE_CODE = 8'h3C
) (
    input  logic [BYTE_W-1:0] sym,
    input  logic              is_k,
    output sym_class_t        cls
);

    always_comb begin
        cls.open_mark  = is_k && (sym == BYTE_W'(OPEN_CODE));
        cls.close_mark = is_k && (sym == BYTE_W'(CLOSE_CODE));
        cls.other_k    = is_k && !cls.open_mark && !cls.close_mark;
    end

endmodule

// File: rtl/seg_index_ctr.sv
module seg_index_ctr #(
    parameter int MAX_BYTES = 2048,
    parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [LEN_W-1:0] idx,
    output logic             full
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    assign full = (idx == LEN_W'(MAX_BYTES));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LEN_W'(MAX_BYTES));

    // R8
    no_step_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && full && !clear));

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 11,
    parameter int LEN_W  = 12
) (
    input  logic [BYTE_W-1:0] seg,
    input  logic [LEN_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    localparam int SHIFT = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] base;

    generate
        if (SHIFT > 0) begin : g_scaled
            assign base = {seg, {SHIFT{1'b0}}};
        end else begin : g_direct
            assign base = ADDR_W'(seg);
        end
    endgenerate

    assign addr = base + ADDR_W'(idx);

endmodule

// File: rtl/seg_frame_parser.sv
module seg_frame_parser
    import seg_parse_pkg::*;
#(
    parameter int         BYTE_W     = 8,
    parameter int         ADDR_W     = 11,
    parameter int         MAX_BYTES  = 2048,
    parameter logic [7:0] OPEN_CODE  = 8'h5C,
    parameter logic [7:0] CLOSE_CODE = 8'h3C,
    localparam int        LEN_W      = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_is_k,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              seg_done,
    output logic [LEN_W-1:0]  seg_len,
    output logic [BYTE_W-1:0] seg_num
);

    parse_state_t      state_q, state_d;
    sym_class_t        cls;
    logic [BYTE_W-1:0] cur_seg;
    logic [LEN_W-1:0]  idx;
    logic              full;
    logic              capture;
    logic              closing;
    logic [ADDR_W-1:0] next_addr;

    seg_sym_classify #(
        .BYTE_W     (BYTE_W),
        .OPEN_CODE  (OPEN_CODE),
        .CLOSE_CODE (CLOSE_CODE)
    ) u_classify (
        .sym  (rx_byte),
        .is_k (rx_is_k),
        .cls  (cls)
    );

    seg_index_ctr #(
        .MAX_BYTES (MAX_BYTES),
        .LEN_W     (LEN_W)
    ) u_index (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cls.open_mark),
        .step  (capture),
        .idx   (idx),
        .full  (full)
    );

    seg_addr_gen #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_addr (
        .seg  (cur_seg),
        .idx  (idx),
        .addr (next_addr)
    );

    assign capture = (state_q == ST_TAKE) && !rx_is_k && !full;
    assign closing = (state_q == ST_TAKE) && cls.close_mark;

    always_comb begin
        state_d = state_q;
        if (cls.open_mark) begin
            state_d = ST_LEAD_SKIP;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_LEAD_SKIP: state_d = ST_ADDR;
                ST_ADDR:      state_d = ST_PAD_SKIP;
                ST_PAD_SKIP:  state_d = ST_TAKE;
                ST_TAKE: begin
                    if (rx_is_k || full) state_d = ST_IDLE;
                    else                 state_d = ST_GAP;
                end
                ST_GAP:       state_d = ST_TAKE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_seg  <= '0;
            wr_valid <= 1'b0;
            wr_data  <= '0;
            wr_addr  <= '0;
            seg_done <= 1'b0;
            seg_len  <= '0;
            seg_num  <= '0;
        end else begin
            wr_valid <= capture;
            seg_done <= closing;
            if (state_q == ST_ADDR && !cls.open_mark) begin
                cur_seg <= rx_byte;
            end
            if (capture) begin
                wr_data <= rx_byte;
                wr_addr <= next_addr;
            end
            if (closing) begin
                seg_len <= idx;
                seg_num <= cur_seg;
            end
        end
    end

    // R3
    alt_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |=> !seg_done);

    // R5
    write_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && seg_done));

    // R2
    open_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_is_k && rx_byte == BYTE_W'(OPEN_CODE)) |=> (!wr_valid && !seg_done));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !seg_done) |=> ##1 (wr_valid && !$past(rx_is_k && rx_byte == BYTE_W'(OPEN_CODE), 2))
            |-> (wr_addr == $past(wr_addr, 2) + 1'b1));

    // R8
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |-> (seg_len <= LEN_W'(MAX_BYTES)));

endmodule

// File: tb/tb_seg_frame_parser.sv
`timescale 1ns/1ps
module tb_seg_frame_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_is_k = 1'b0;
    logic        wr_valid;
    logic [7:0]  wr_data;
    logic [10:0] wr_addr;
    logic        seg_done;
    logic [11:0] seg_len;
    logic [7:0]  seg_num;

    always #2 clk = ~clk;

    seg_frame_parser dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .rx_is_k  (rx_is_k),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_addr  (wr_addr),
        .seg_done (seg_done),
        .seg_len  (seg_len),
        .seg_num  (seg_num)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    finished = 0;

    bit          m_in;
    int          m_pos;
    int          m_cnt;
    logic [7:0]  m_seg;
    bit          e_valid;
    logic [7:0]  e_data;
    logic [10:0] e_addr;
    bit          e_done;
    logic [11:0] e_len;
    logic [7:0]  e_num;
    int          done_seen;
    int          write_seen;

    function automatic logic [10:0] exp_addr(logic [7:0] s, int i);
        return 11'((int'(s) * 8 + i) % 2048);
    endfunction

    task automatic check(string req, bit ok, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step(logic [7:0] b, bit k);
        e_valid = 0;
        e_done  = 0;
        if (k && b == 8'h5C) begin
            m_in = 1; m_pos = 0; m_cnt = 0;
        end else if (m_in) begin
            m_pos++;
            if (m_pos == 2) m_seg = b;
            if (m_pos >= 4 && (m_pos % 2) == 0) begin
                if (k && b == 8'h3C) begin
                    e_done = 1; e_len = 12'(m_cnt); e_num = m_seg; m_in = 0;
                end else if (k || m_cnt == 2048) begin
                    m_in = 0;
                end else begin
                    e_valid = 1; e_data = b; e_addr = exp_addr(m_seg, m_cnt);
                    m_cnt++;
                end
            end
        end
    endtask

    task automatic send(logic [7:0] b, bit k);
        @(negedge clk);
        rx_byte = b;
        rx_is_k = k;
        model_step(b, k);
        @(posedge clk);
        #1;
        if (wr_valid) write_seen++;
        if (seg_done) done_seen++;
        check(cur_req, wr_valid == e_valid, "wr_valid", wr_valid, e_valid);
        if (e_valid && wr_valid) begin
            check(cur_req, wr_data == e_data, "wr_data", wr_data, e_data);
            check(cur_req, wr_addr == e_addr, "wr_addr", wr_addr, e_addr);
        end
        check(cur_req, seg_done == e_done, "seg_done", seg_done, e_done);
        if (e_done && seg_done) begin
            check(cur_req, seg_len == e_len, "seg_len", seg_len, e_len);
            check(cur_req, seg_num == e_num, "seg_num", seg_num, e_num);
        end
    endtask

    task automatic gap_byte();
        logic [7:0] g;
        bit gk;
        g  = 8'($urandom);
        gk = ($urandom % 6) == 0;
        if (gk && g == 8'h5C) g = 8'h3C;
        send(g, gk);
    endtask

    task automatic frame_head(logic [7:0] s);
        send(8'h5C, 1);
        send(8'($urandom), 0);
        send(s, 0);
        send(8'($urandom), 0);
    endtask

    task automatic frame_body(int n, bit do_close);
        for (int i = 0; i < n; i++) begin
            send(8'($urandom), 0);
            gap_byte();
        end
        if (do_close) send(8'h3C, 1);
    endtask

    task automatic junk(int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] j;
            j = 8'($urandom);
            if (j == 8'h5C) j = 8'h11;
            send(j, ($urandom % 4) == 0);
        end
    endtask

    initial begin
        #900000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5E6F_0042));
        m_in = 0; m_pos = 0; m_cnt = 0; m_seg = 0;
        done_seen = 0; write_seen = 0;
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        check("R1", wr_valid == 0 && seg_done == 0, "reset strobes", {wr_valid, seg_done}, 0);
        check("R1", wr_data == 0 && wr_addr == 0, "reset write bus", {wr_data, wr_addr}, 0);
        check("R1", seg_len == 0 && seg_num == 0, "reset report", {seg_len, seg_num}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", wr_valid == 0 && seg_done == 0 && seg_len == 0, "after release",
              {wr_valid, seg_done, seg_len}, 0);

        cur_req = "R9";
        send(8'h3C, 1); send(8'h3C, 1); send(8'hBC, 1);
        junk(20);
        check("R9", done_seen == 0 && write_seen == 0, "activity outside frame",
              done_seen + write_seen, 0);

        cur_req = "R3";
        frame_head(8'h12);
        frame_body(5, 1);

        cur_req = "R5";
        done_seen = 0;
        frame_head(8'h40);
        send(8'h3C, 1);
        check("R5", done_seen == 1, "empty frame done count", done_seen, 1);

        cur_req = "R4";
        frame_head(8'hFF);
        frame_body(12, 1);

        cur_req = "R6";
        done_seen = 0;
        frame_head(8'h07);
        send(8'hA1, 0); send(8'h3C, 1);
        send(8'hA2, 0); send(8'h3C, 1);
        send(8'hA3, 0); send(8'h00, 0);
        send(8'h3C, 1);
        check("R6", done_seen == 1, "gap close ignored, one done", done_seen, 1);

        cur_req = "R7";
        done_seen = 0; write_seen = 0;
        frame_head(8'h21);
        send(8'hB0, 0); send(8'h00, 0);
        send(8'hBC, 1);
        for (int i = 0; i < 6; i++) send(8'(i + 1), 0);
        send(8'h3C, 1);
        send(8'h00, 0); send(8'h3C, 1);
        check("R7", done_seen == 0 && write_seen == 1, "abort drops rest",
              done_seen * 16 + write_seen, 1);

        cur_req = "R10";
        done_seen = 0;
        frame_head(8'h33);
        send(8'hC0, 0); send(8'h00, 0);
        send(8'hC1, 0);
        frame_head(8'h34);
        frame_body(3, 1);
        check("R10", done_seen == 1, "restart single done", done_seen, 1);

        cur_req = "R2";
        send(8'h5C, 1); send(8'h00, 0); send(8'h5C, 1); send(8'h00, 0);
        send(8'h66, 0); send(8'h5C, 1);
        send(8'h00, 0); send(8'h55, 0); send(8'h00, 0);
        frame_body(4, 1);

        cur_req = "R8";
        done_seen = 0;
        frame_head(8'h80);
        frame_body(2048, 1);
        check("R8", done_seen == 1, "full segment closes", done_seen, 1);
        done_seen = 0; write_seen = 0;
        frame_head(8'h81);
        frame_body(2048, 0);
        write_seen = 0;
        send(8'hEE, 0);
        send(8'h00, 0);
        send(8'h3C, 1);
        check("R8", done_seen == 0 && write_seen == 0, "overflow aborts",
              done_seen * 16 + write_seen, 0);

        cur_req = "R3";
        for (int f = 0; f < 40; f++) begin
            frame_head(8'($urandom));
            frame_body(int'($urandom % 24), ($urandom % 5) != 0);
            junk(int'($urandom % 6));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule